// File: doc/BRIEF.md
# Cipher-Feedback DMA Trigger Sequencer

This block paces automatic cipher-feedback processing of a run of 128-bit blocks. It sits beside a block-cipher core and three 128-bit data ports: an XOR-input port, a data-output port and a plain data-input port. It watches the core's completion signal and every bus access to those ports. From these it raises DMA request pulses in the order the chosen operation needs. Each request repeats after every access it serves, until 16 bytes have moved through that port. Accesses may be bytes or half-words.

Software sets the operation code and writes a non-zero block count, and the sequence starts. For each block, the sequencer waits for the core to finish. It then requests the XOR-input writes, then the data-output reads and, when decrypting, the data-input writes. When the last phase of a block ends, the count is decremented. If blocks remain, the core is restarted. When the count reaches zero, the sequencer goes back to idle. While blocks are outstanding, key writes are blocked, because the core restores its key from a shadow copy for every block.

Top module: `cfb_dma_pacer`

## Requirements
- R1: While `mode_en` is 0, `trig` stays 0 and block-count writes are ignored, so `blocks_left` stays 0.
- R2: The operation code is captured when the count is written. Code 00 and code 10 select encryption. Codes 01 and 11 select decryption (bit 0 set).
- R3: `trig` bit 0 pulses for one cycle on the cycle after `core_done`. It pulses again on the cycle after each XOR-input write, until that port has received 16 bytes.
- R4: On the cycle after the XOR-input write that completes 16 bytes, `trig` bit 1 pulses. It pulses again after each data-output read, until 16 bytes have been read.
- R5: `trig` bit 2 never pulses during encryption. During decryption it pulses on the cycle after the data-output read that completes 16 bytes. It then repeats after each data-input write, until 16 bytes have been written.
- R6: Each served access counts 1 byte, or 2 bytes when its half flag is set. A phase ends on the access that brings its total to 16 or more.
- R7: Writing a non-zero count while idle loads `blocks_left` and waits for `core_done`. A count of zero, or a count written while a sequence is running, is ignored.
- R8: When the final phase of a block ends, `blocks_left` is decremented on the next cycle. If blocks remain, `core_start` pulses on that same cycle. Otherwise the sequencer returns to idle.
- R9: `key_load` follows `key_wr` only while `blocks_left` is 0.
- R10: Accesses to a port whose phase is not active produce no trigger and do not advance any byte count.
- R11: Reset, or clearing `mode_en` mid-sequence, returns the block to idle. It clears `blocks_left`, the byte count and any pending trigger.
- R12: At most one `trig` bit is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | Cipher-mode DMA enable |
| op_code | input | 2 | Operation code; bit 0 set means decrypt |
| cnt_wr | input | 1 | Block-count write strobe |
| cnt_val | input | CNT_W | Block count to load |
| key_wr | input | 1 | Key write strobe from the bus |
| key_load | output | 1 | Key write passed to the key register |
| core_done | input | 1 | Core finished a block |
| core_start | output | 1 | One-cycle start of the next block |
| xin_wr | input | 1 | Write access to the XOR-input port |
| xin_half | input | 1 | That access is a half-word |
| dout_rd | input | 1 | Read access to the data-output port |
| dout_half | input | 1 | That access is a half-word |
| din_wr | input | 1 | Write access to the data-input port |
| din_half | input | 1 | That access is a half-word |
| trig | output | 3 | DMA request pulses, one bit per port phase |
| blocks_left | output | CNT_W | Blocks still to be processed |

## Verification
The sequence is run with all-byte accesses, all-half-word accesses, alternating byte and half-word accesses, and fifteen bytes followed by a half-word. Together these separate exact 16-byte completion from overshoot completion, and show that the size flags are weighted correctly. Encryption and decryption runs of one and two blocks tell the two-phase order from the three-phase order, and show the restart and decrement between blocks. Stray accesses to idle ports are mixed into a phase, and the phase still ends on exactly the sixteenth real byte. A run aborted part way through is followed by a full block, which shows that no byte count survives the abort.

// File: rtl/cfb_dma_pacer.sv
module cfb_dma_pacer #(
  parameter int CNT_W = 8,
  parameter int BLK_BYTES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_en,
  input  logic [1:0]       op_code,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             key_wr,
  output logic             key_load,
  input  logic             core_done,
  output logic             core_start,
  input  logic             xin_wr,
  input  logic             xin_half,
  input  logic             dout_rd,
  input  logic             dout_half,
  input  logic             din_wr,
  input  logic             din_half,
  output logic [2:0]       trig,
  output logic [CNT_W-1:0] blocks_left
);
  localparam int BW = $clog2(BLK_BYTES + 2);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_XIN, S_OUT, S_DIN} st_t;

  st_t              st;
  logic             dec_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    bytes_q;
  logic [2:0]       trig_q;
  logic             start_q;

  logic          hit, hit_half, phase_done, last_phase;
  logic [BW-1:0] bytes_nx;
  logic [2:0]    own_bit;

  assign hit = (st == S_XIN && xin_wr) || (st == S_OUT && dout_rd) ||
               (st == S_DIN && din_wr);
  assign hit_half = (st == S_XIN) ? xin_half :
                    (st == S_OUT) ? dout_half : din_half;
  assign bytes_nx   = bytes_q + (hit_half ? BW'(2) : BW'(1));
  assign phase_done = hit && (bytes_nx >= BW'(BLK_BYTES));
  assign last_phase = (st == S_DIN) || (st == S_OUT && !dec_q);
  assign own_bit    = (st == S_XIN) ? 3'b001 :
                      (st == S_OUT) ? 3'b010 : 3'b100;

  assign trig        = trig_q;
  assign core_start  = start_q;
  assign blocks_left = cnt_q;
  assign key_load    = key_wr && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      dec_q   <= 1'b0;
      cnt_q   <= '0;
      bytes_q <= '0;
      trig_q  <= '0;
      start_q <= 1'b0;
    end else if (!mode_en) begin
      st      <= S_IDLE;
      cnt_q   <= '0;
      bytes_q <= '0;
      trig_q  <= '0;
      start_q <= 1'b0;
    end else begin
      trig_q  <= '0;
      start_q <= 1'b0;
      case (st)
        S_IDLE: if (cnt_wr && cnt_val != '0) begin
          cnt_q <= cnt_val;
          dec_q <= op_code[0];
          st    <= S_WAIT;
        end
        S_WAIT: if (core_done) begin
          st      <= S_XIN;
          bytes_q <= '0;
          trig_q  <= 3'b001;
        end
        default: if (hit) begin
          if (!phase_done) begin
            bytes_q <= bytes_nx;
            trig_q  <= own_bit;
          end else begin
            bytes_q <= '0;
            if (last_phase) begin
              cnt_q <= cnt_q - 1'b1;
              if (cnt_q == CNT_W'(1)) st <= S_IDLE;
              else begin
                st      <= S_WAIT;
                start_q <= 1'b1;
              end
            end else if (st == S_XIN) begin
              st     <= S_OUT;
              trig_q <= 3'b010;
            end else begin
              st     <= S_DIN;
              trig_q <= 3'b100;
            end
          end
        end
      endcase
    end
  end

  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |=> trig == 3'b000);
  assert_no_enc_din_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trig[2] |-> dec_q);
  assert_bytes_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bytes_q < BW'(BLK_BYTES));
  assert_start_decrements_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> (blocks_left == $past(blocks_left) - 1'b1) && blocks_left != '0);
  assert_one_trig_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig));
endmodule

// File: tb/test_cfb_dma_pacer.sv
module test_cfb_dma_pacer;
  logic clk = 0, rst_n = 0, mode_en = 0, cnt_wr = 0, key_wr = 0, core_done = 0;
  logic [1:0] op_code = 0;
  logic [7:0] cnt_val = 0;
  logic xin_wr = 0, xin_half = 0, dout_rd = 0, dout_half = 0, din_wr = 0, din_half = 0;
  logic key_load, core_start;
  logic [2:0] trig;
  logic [7:0] blocks_left;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  cfb_dma_pacer i_cfb_dma_pacer (
    .clk, .rst_n, .mode_en, .op_code, .cnt_wr, .cnt_val, .key_wr, .key_load,
    .core_done, .core_start, .xin_wr, .xin_half, .dout_rd, .dout_half,
    .din_wr, .din_half, .trig, .blocks_left);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input int port, input bit half);
    case (port)
      0: begin xin_wr = 1; xin_half = half; end
      1: begin dout_rd = 1; dout_half = half; end
      default: begin din_wr = 1; din_half = half; end
    endcase
    @(negedge clk);
    xin_wr = 0; dout_rd = 0; din_wr = 0;
    xin_half = 0; dout_half = 0; din_half = 0;
  endtask

  task automatic pulse_done();
    core_done = 1; @(negedge clk); core_done = 0;
  endtask

  task automatic load(input int n, input logic [1:0] op);
    op_code = op; cnt_val = 8'(n); cnt_wr = 1;
    @(negedge clk); cnt_wr = 0;
  endtask

  function automatic bit pick(input int pat, input int k, input int sent);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return k[0];
      default: return sent == 15;
    endcase
  endfunction

  // R6: sizes accumulate; the phase ends exactly when 16 bytes are reached
  task automatic run_phase(input int port, input int pat, input int own, input int nxt,
                           input int nstart, input string tag);
    int sent = 0;
    int k = 0;
    while (sent < 16) begin
      bit h = pick(pat, k, sent);
      access(port, h);
      sent += h ? 2 : 1;
      k++;
      if (sent < 16) chk({tag, " R6 retrigger R12"}, int'(trig), own);
      else begin
        chk({tag, " R6 phase end"}, int'(trig), nxt);
        chk({tag, " R8 start"}, int'(core_start), nstart);
      end
    end
  endtask

  task automatic run_block(input bit dec, input int pat, input int rem);
    pulse_done();
    chk("R3 first trigger", int'(trig), 1);
    run_phase(0, pat, 1, 2, 0, "R3 R4");
    if (dec) begin
      run_phase(1, pat, 2, 4, 0, "R4 R5");
      run_phase(2, pat, 4, 0, rem > 0, "R5");
    end else run_phase(1, pat, 2, 0, rem > 0, "R4 R5 enc");
    chk("R8 count", int'(blocks_left), rem);
  endtask

  task automatic t_reset();
    chk("R11 reset trig", int'(trig), 0);
    chk("R11 reset start", int'(core_start), 0);
    chk("R11 reset count", int'(blocks_left), 0);
  endtask

  task automatic t_enc();
    load(1, 2'b00);
    chk("R7 load", int'(blocks_left), 1);
    run_block(0, 0, 0);
    load(2, 2'b10);
    chk("R2 code 10", int'(blocks_left), 2);
    run_block(0, 1, 1);
    run_block(0, 2, 0);
  endtask

  task automatic t_dec();
    load(2, 2'b01);
    run_block(1, 0, 1);
    run_block(1, 3, 0);
    load(1, 2'b11);
    run_block(1, 1, 0);
  endtask

  task automatic t_wrong_port();
    load(1, 2'b00);
    pulse_done();
    chk("R10 first", int'(trig), 1);
    access(1, 0); chk("R10 dout in xin phase", int'(trig), 0);
    access(2, 1); chk("R10 din in xin phase", int'(trig), 0);
    run_phase(0, 0, 1, 2, 0, "R10 xin");
    access(0, 1); chk("R10 xin in out phase", int'(trig), 0);
    access(2, 0); chk("R10 din in enc out phase", int'(trig), 0);
    run_phase(1, 0, 2, 0, 0, "R10 out");
    chk("R10 done", int'(blocks_left), 0);
  endtask

  task automatic t_key();
    key_wr = 1; #1; chk("R9 key idle", int'(key_load), 1);
    @(negedge clk); key_wr = 0;
    load(1, 2'b00);
    key_wr = 1; #1; chk("R9 key blocked", int'(key_load), 0);
    @(negedge clk); key_wr = 0;
    run_block(0, 0, 0);
    key_wr = 1; #1; chk("R9 key after", int'(key_load), 1);
    @(negedge clk); key_wr = 0;
  endtask

  task automatic t_abort();
    load(3, 2'b01);
    pulse_done();
    for (int i = 0; i < 3; i++) access(0, 1);
    mode_en = 0; @(negedge clk);
    chk("R11 abort trig", int'(trig), 0);
    chk("R11 abort count", int'(blocks_left), 0);
    load(2, 2'b00);
    chk("R1 count ignored", int'(blocks_left), 0);
    pulse_done();
    chk("R1 no trig", int'(trig), 0);
    access(0, 0);
    chk("R1 no trig access", int'(trig), 0);
    mode_en = 1; @(negedge clk);
    pulse_done();
    chk("R11 idle after abort", int'(trig), 0);
    load(1, 2'b00);
    run_block(0, 0, 0);
    load(1, 2'b01);
    pulse_done();
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R11 reset mid trig", int'(trig), 0);
    chk("R11 reset mid count", int'(blocks_left), 0);
  endtask

  task automatic t_zero();
    load(0, 2'b00);
    chk("R7 zero count", int'(blocks_left), 0);
    pulse_done();
    chk("R7 zero no trig", int'(trig), 0);
    load(1, 2'b00);
    load(3, 2'b01);
    chk("R7 busy write ignored", int'(blocks_left), 1);
    run_block(0, 0, 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1; mode_en = 1;
    @(negedge clk);
    t_enc();
    t_dec();
    t_wrong_port();
    t_key();
    t_abort();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule